// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit virtual address into a physical address. It follows two levels of page tables kept in ordinary memory. The virtual address has three fields. The top index picks a word in the root table, and that word names the frame which holds a second-level table. The middle index picks a word in that second-level table, and that word names the data frame. The low bits are the byte offset, which passes through to the result unchanged.

A walk costs two reads on a plain request/response memory port. A missing second-level table shows up as a root word whose present bit is clear. In that case the walker stops after the first read and reports a level-1 fault. An absent data page produces a level-2 fault.

The block takes one request at a time. A root-frame register, loaded through a write strobe, says where the root table lives.

Top module: `pt_walker`

## Requirements
- R1: While reset is held and after it is released, req_ready_o is 1, rsp_valid_o is 0 and mem_req_o is 0.
- R2: The first read of a walk is at root_frame * 4096 + va[31:22] * 4, where root_frame is the root register value.
- R3: If bit 0 (present) of the first word is 1, the second read is at word[31:12] * 4096 + va[21:12] * 4. If bit 0 is 0, no second read is issued.
- R4: If the second word has bit 0 set, the walk ends with rsp_fault_o = 0 and rsp_pa_o = {word[31:12], va[11:0]}.
- R5: On a successful walk, rsp_ref_o = bit 1, rsp_mod_o = bit 2 and rsp_prot_o = bits 4:3 of the second-level word.
- R6: A first-level word with bit 0 clear ends the walk after exactly one read. The response has rsp_fault_o = 1, rsp_fault_lvl_o = 1 and rsp_fault_va_o equal to the request address.
- R7: A second-level word with bit 0 clear ends the walk with rsp_fault_o = 1, rsp_fault_lvl_o = 2 and rsp_fault_va_o equal to the request address.
- R8: Only one walk is in flight. req_ready_o is 0 from the accepting edge until after the response. rsp_valid_o is high for exactly one cycle per accepted request.
- R9: mem_req_o stays high with a stable mem_addr_o until mem_gnt_i. Read data is taken only on mem_rvalid_i after that grant.
- R10: root_we_i loads root_frame_i into the root register. A walk uses the value the register held when the request was accepted, so a write during a walk affects only later walks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| root_we_i | input | 1 | Load strobe for the root-frame register |
| root_frame_i | input | 20 | New root-table frame number |
| req_valid_i | input | 1 | Translation request |
| req_ready_o | output | 1 | Walker idle, request accepted |
| req_va_i | input | 32 | Virtual address to translate |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 32 | Byte address of the table word |
| mem_gnt_i | input | 1 | Memory accepted the read |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 32 | Table word read |
| rsp_valid_o | output | 1 | Result valid for one cycle |
| rsp_fault_o | output | 1 | Translation failed |
| rsp_fault_lvl_o | output | 2 | Level that faulted (1 or 2), 0 on success |
| rsp_fault_va_o | output | 32 | Virtual address of the walk |
| rsp_pa_o | output | 32 | Physical address, 0 on fault |
| rsp_ref_o | output | 1 | Referenced bit of the final entry |
| rsp_mod_o | output | 1 | Modified bit of the final entry |
| rsp_prot_o | output | 2 | Protection field of the final entry |

## Verification
The bound checker watches the port protocol on every cycle:
- one walk in flight at a time, and ready is never raised during a walk;
- a one-cycle response;
- a held, stable memory request until it is granted;
- a read count of one for level-1 faults and two otherwise;
- the offset and faulting address agreeing with the accepted request.

Only the bench's sweep over table indices, offsets, grant stalls and read latencies can show that each read lands at the computed table address. The same holds for the translated frame and status bits, and for which level reports absence. The bench alone also shows that a root write during a walk affects only later walks.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_READ_L1,
    S_WAIT_L1,
    S_READ_L2,
    S_WAIT_L2,
    S_DONE
  } walk_state_e;

  localparam int unsigned LVL_W    = 2;
  localparam int unsigned PROT_W   = 2;
  localparam int unsigned FLAG_TOP = 4;  // highest status bit in an entry
endpackage

// File: rtl/pt_va_split.sv
module pt_va_split #(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned L1_W  = 10,
  parameter int unsigned L2_W  = 10,
  parameter int unsigned OFF_W = VA_W - L1_W - L2_W
) (
  input  logic [VA_W-1:0]  va_i,
  output logic [L1_W-1:0]  l1_idx_o,
  output logic [L2_W-1:0]  l2_idx_o,
  output logic [OFF_W-1:0] off_o
);
  assign l1_idx_o = va_i[VA_W-1 -: L1_W];
  assign l2_idx_o = va_i[OFF_W +: L2_W];
  assign off_o    = va_i[OFF_W-1:0];
endmodule

// File: rtl/pt_entry_addr.sv
module pt_entry_addr #(
  parameter int unsigned PA_W    = 32,
  parameter int unsigned OFF_W   = 12,
  parameter int unsigned IDX_W   = 10,
  parameter int unsigned PTE_W   = 32,
  parameter int unsigned FRAME_W = PA_W - OFF_W
) (
  input  logic [FRAME_W-1:0] frame_i,
  input  logic [IDX_W-1:0]   idx_i,
  output logic [PA_W-1:0]    addr_o
);
  localparam int unsigned ESH = $clog2(PTE_W / 8);

  assign addr_o = {frame_i, {OFF_W{1'b0}}} + (PA_W'(idx_i) << ESH);
endmodule

// File: rtl/pt_entry_decode.sv
module pt_entry_decode
  import pt_walker_pkg::*;
#(
  parameter int unsigned PTE_W   = 32,
  parameter int unsigned FRAME_W = 20
) (
  input  logic [PTE_W-1:0]   word_i,
  output logic               valid_o,
  output logic               ref_o,
  output logic               mod_o,
  output logic [PROT_W-1:0]  prot_o,
  output logic [FRAME_W-1:0] frame_o
);
  localparam int unsigned RSV_LO = FLAG_TOP + 1;
  localparam int unsigned RSV_HI = PTE_W - FRAME_W - 1;

  assign valid_o = word_i[0];
  assign ref_o   = word_i[1];
  assign mod_o   = word_i[2];
  assign prot_o  = word_i[FLAG_TOP -: PROT_W];
  assign frame_o = word_i[PTE_W-1 -: FRAME_W];

  logic unused_rsvd;
  assign unused_rsvd = ^word_i[RSV_HI:RSV_LO];
endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
  import pt_walker_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        req_fire_i,
  input  logic        mem_gnt_i,
  input  logic        mem_rvalid_i,
  input  logic        pte_valid_i,
  output walk_state_e state_o
);
  walk_state_e state_d;

  always_comb begin
    state_d = state_o;
    unique case (state_o)
      S_IDLE:    if (req_fire_i)   state_d = S_READ_L1;
      S_READ_L1: if (mem_gnt_i)    state_d = S_WAIT_L1;
      S_WAIT_L1: if (mem_rvalid_i) state_d = pte_valid_i ? S_READ_L2 : S_DONE;
      S_READ_L2: if (mem_gnt_i)    state_d = S_WAIT_L2;
      S_WAIT_L2: if (mem_rvalid_i) state_d = S_DONE;
      S_DONE:                      state_d = S_IDLE;
      default:                     state_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_o <= S_IDLE;
    else         state_o <= state_d;
  end
endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int unsigned VA_W       = 32,
  parameter int unsigned L1_W       = 10,
  parameter int unsigned L2_W       = 10,
  parameter int unsigned PA_W       = 32,
  parameter int unsigned PTE_W      = 32,
  parameter int unsigned ROOT_RST   = 0,
  localparam int unsigned OFF_W     = VA_W - L1_W - L2_W,
  localparam int unsigned FRAME_W   = PA_W - OFF_W
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               root_we_i,
  input  logic [FRAME_W-1:0] root_frame_i,
  input  logic               req_valid_i,
  output logic               req_ready_o,
  input  logic [VA_W-1:0]    req_va_i,
  output logic               mem_req_o,
  output logic [PA_W-1:0]    mem_addr_o,
  input  logic               mem_gnt_i,
  input  logic               mem_rvalid_i,
  input  logic [PTE_W-1:0]   mem_rdata_i,
  output logic               rsp_valid_o,
  output logic               rsp_fault_o,
  output logic [LVL_W-1:0]   rsp_fault_lvl_o,
  output logic [VA_W-1:0]    rsp_fault_va_o,
  output logic [PA_W-1:0]    rsp_pa_o,
  output logic               rsp_ref_o,
  output logic               rsp_mod_o,
  output logic [PROT_W-1:0]  rsp_prot_o
);
  walk_state_e        state;
  logic               req_fire;
  logic [VA_W-1:0]    va_q;
  logic [FRAME_W-1:0] root_q, walk_root_q, l1_frame_q;
  logic [L1_W-1:0]    l1_idx;
  logic [L2_W-1:0]    l2_idx;
  logic [OFF_W-1:0]   off;
  logic [PA_W-1:0]    l1_addr, l2_addr;
  logic               pte_valid, pte_ref, pte_mod;
  logic [PROT_W-1:0]  pte_prot;
  logic [FRAME_W-1:0] pte_frame;
  logic               l1_rsp, l2_rsp;

  assign req_ready_o = (state == S_IDLE);
  assign req_fire    = req_valid_i & req_ready_o;
  assign l1_rsp      = (state == S_WAIT_L1) & mem_rvalid_i;
  assign l2_rsp      = (state == S_WAIT_L2) & mem_rvalid_i;

  pt_va_split #(.VA_W(VA_W), .L1_W(L1_W), .L2_W(L2_W), .OFF_W(OFF_W)) u_split (
    .va_i(va_q), .l1_idx_o(l1_idx), .l2_idx_o(l2_idx), .off_o(off)
  );

  pt_entry_addr #(.PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(L1_W), .PTE_W(PTE_W)) u_l1_addr (
    .frame_i(walk_root_q), .idx_i(l1_idx), .addr_o(l1_addr)
  );

  pt_entry_addr #(.PA_W(PA_W), .OFF_W(OFF_W), .IDX_W(L2_W), .PTE_W(PTE_W)) u_l2_addr (
    .frame_i(l1_frame_q), .idx_i(l2_idx), .addr_o(l2_addr)
  );

  pt_entry_decode #(.PTE_W(PTE_W), .FRAME_W(FRAME_W)) u_dec (
    .word_i(mem_rdata_i), .valid_o(pte_valid), .ref_o(pte_ref), .mod_o(pte_mod),
    .prot_o(pte_prot), .frame_o(pte_frame)
  );

  pt_walk_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .req_fire_i(req_fire), .mem_gnt_i(mem_gnt_i),
    .mem_rvalid_i(mem_rvalid_i), .pte_valid_i(pte_valid), .state_o(state)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        root_q <= FRAME_W'(ROOT_RST);
    else if (root_we_i) root_q <= root_frame_i;
  end

  // request capture and first-level pointer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      va_q        <= '0;
      walk_root_q <= '0;
      l1_frame_q  <= '0;
    end else begin
      if (req_fire) begin
        va_q        <= req_va_i;
        walk_root_q <= root_q;
      end
      if (l1_rsp && pte_valid) l1_frame_q <= pte_frame;
    end
  end

  // result registers
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_fault_o     <= 1'b0;
      rsp_fault_lvl_o <= '0;
      rsp_pa_o        <= '0;
      rsp_ref_o       <= 1'b0;
      rsp_mod_o       <= 1'b0;
      rsp_prot_o      <= '0;
    end else if (req_fire) begin
      rsp_fault_o     <= 1'b0;
      rsp_fault_lvl_o <= '0;
      rsp_pa_o        <= '0;
      rsp_ref_o       <= 1'b0;
      rsp_mod_o       <= 1'b0;
      rsp_prot_o      <= '0;
    end else if (l1_rsp && !pte_valid) begin
      rsp_fault_o     <= 1'b1;
      rsp_fault_lvl_o <= LVL_W'(1);
    end else if (l2_rsp) begin
      if (pte_valid) begin
        rsp_pa_o   <= {pte_frame, off};
        rsp_ref_o  <= pte_ref;
        rsp_mod_o  <= pte_mod;
        rsp_prot_o <= pte_prot;
      end else begin
        rsp_fault_o     <= 1'b1;
        rsp_fault_lvl_o <= LVL_W'(2);
      end
    end
  end

  assign mem_req_o      = (state == S_READ_L1) | (state == S_READ_L2);
  assign mem_addr_o     = (state == S_READ_L2) ? l2_addr : l1_addr;
  assign rsp_valid_o    = (state == S_DONE);
  assign rsp_fault_va_o = va_q;
endmodule

// File: rtl/pt_walker_checker.sv
module pt_walker_checker #(
  parameter int unsigned VA_W  = 32,
  parameter int unsigned PA_W  = 32,
  parameter int unsigned OFF_W = 12
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            req_valid_i,
  input logic            req_ready_o,
  input logic [VA_W-1:0] req_va_i,
  input logic            mem_req_o,
  input logic [PA_W-1:0] mem_addr_o,
  input logic            mem_gnt_i,
  input logic            rsp_valid_o,
  input logic            rsp_fault_o,
  input logic [1:0]      rsp_fault_lvl_o,
  input logic [VA_W-1:0] rsp_fault_va_o,
  input logic [PA_W-1:0] rsp_pa_o
);
  logic            busy;
  logic [VA_W-1:0] va_q;
  logic [1:0]      grants;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy   <= 1'b0;
      va_q   <= '0;
      grants <= '0;
    end else begin
      if (req_valid_i && req_ready_o) begin
        busy   <= 1'b1;
        va_q   <= req_va_i;
        grants <= '0;
      end else begin
        if (mem_req_o && mem_gnt_i) grants <= grants + 2'd1;
        if (rsp_valid_o)            busy   <= 1'b0;
      end
    end
  end

  a_r8_not_ready_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy |-> !req_ready_o);
  a_r8_rsp_in_walk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> busy);
  a_r8_rsp_one_cycle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  a_r9_hold_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_gnt_i) |=> (mem_req_o && $stable(mem_addr_o)));
  a_r9_no_req_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !mem_req_o);
  a_r4_offset_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !rsp_fault_o) |-> (rsp_pa_o[OFF_W-1:0] == va_q[OFF_W-1:0]));
  a_r6_one_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o && rsp_fault_lvl_o == 2'd1) |-> (grants == 2'd1));
  a_r7_two_reads: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && (!rsp_fault_o || rsp_fault_lvl_o == 2'd2)) |-> (grants == 2'd2));
  a_r6_fault_va: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o) |-> (rsp_fault_va_o == va_q));
  a_r7_fault_lvl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && rsp_fault_o) |-> (rsp_fault_lvl_o == 2'd1 || rsp_fault_lvl_o == 2'd2));
endmodule

bind pt_walker pt_walker_checker #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_valid_i(req_valid_i), .req_ready_o(req_ready_o),
  .req_va_i(req_va_i), .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o),
  .mem_gnt_i(mem_gnt_i), .rsp_valid_o(rsp_valid_o), .rsp_fault_o(rsp_fault_o),
  .rsp_fault_lvl_o(rsp_fault_lvl_o), .rsp_fault_va_o(rsp_fault_va_o), .rsp_pa_o(rsp_pa_o)
);

// File: tb/pt_walker_bench.sv
`timescale 1ns/1ps
module pt_walker_bench;
  localparam logic [19:0] ROOT_A = 20'h00010;
  localparam logic [19:0] ROOT_B = 20'h00011;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        root_we_i = 1'b0;
  logic [19:0] root_frame_i = '0;
  logic        req_valid_i = 1'b0;
  logic        req_ready_o;
  logic [31:0] req_va_i = '0;
  logic        mem_req_o;
  logic [31:0] mem_addr_o;
  logic        mem_gnt_i;
  logic        mem_rvalid_i;
  logic [31:0] mem_rdata_i;
  logic        rsp_valid_o, rsp_fault_o, rsp_ref_o, rsp_mod_o;
  logic [1:0]  rsp_fault_lvl_o, rsp_prot_o;
  logic [31:0] rsp_fault_va_o, rsp_pa_o;

  int total = 0;
  int bad = 0;
  int lat = 0;
  int n_rd = 0;
  logic [31:0] addr_log [4];

  always #4 clk_i = ~clk_i;

  pt_walker u_pt_walker (
    .clk_i, .rst_ni, .root_we_i, .root_frame_i, .req_valid_i, .req_ready_o, .req_va_i,
    .mem_req_o, .mem_addr_o, .mem_gnt_i, .mem_rvalid_i, .mem_rdata_i,
    .rsp_valid_o, .rsp_fault_o, .rsp_fault_lvl_o, .rsp_fault_va_o, .rsp_pa_o,
    .rsp_ref_o, .rsp_mod_o, .rsp_prot_o
  );

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [19:0] l2_frame(input int i, input int j, input bit alt);
    logic [19:0] f;
    f = {10'(i), 10'(j)};
    return alt ? (f ^ 20'hF0F0F) : f;
  endfunction

  // table memory: root tables at ROOT_A/ROOT_B, leaf tables at 0x20000+i / 0x30000+i
  function automatic logic [31:0] mem_word(input logic [31:0] a);
    logic [19:0] fr;
    int idx, i, fl;
    bit v;
    fr  = a[31:12];
    idx = int'(a[11:2]);
    if (fr == ROOT_A || fr == ROOT_B) begin
      v = (idx % 7) != 3;
      return {((fr == ROOT_A) ? 20'h20000 : 20'h30000) + 20'(idx), 11'b0, v};
    end
    if (fr[19:10] == 10'h080 || fr[19:10] == 10'h0C0) begin
      i  = int'(fr[9:0]);
      v  = ((i + idx) % 5) != 2;
      fl = (i * 3 + idx) % 16;
      return {l2_frame(i, idx, fr[19:10] == 10'h0C0), 7'b0, 4'(fl), v};
    end
    return 32'h0;
  endfunction

  // memory responder
  initial begin
    bit pend;
    int lc, gw;
    logic [31:0] pend_addr, held;
    mem_gnt_i = 1'b0; mem_rvalid_i = 1'b0; mem_rdata_i = '0;
    pend = 1'b0; lc = 0; gw = 0; pend_addr = '0; held = '0;
    forever begin
      @(negedge clk_i);
      mem_rvalid_i = 1'b0;
      if (mem_gnt_i) begin
        mem_gnt_i = 1'b0; pend = 1'b1; lc = lat;
      end else if (pend) begin
        if (lc == 0) begin
          mem_rvalid_i = 1'b1; mem_rdata_i = mem_word(pend_addr); pend = 1'b0;
        end else lc--;
      end else if (mem_req_o) begin
        if (gw == 0) held = mem_addr_o;
        else chk(mem_addr_o == held, "R9 addr held", 64'(mem_addr_o), 64'(held));
        if (gw >= lat) begin
          mem_gnt_i = 1'b1; pend_addr = mem_addr_o;
          if (n_rd < 4) addr_log[n_rd] = mem_addr_o;
          n_rd++; gw = 0;
        end else gw++;
      end
    end
  end

  task automatic walk(input logic [31:0] va, input logic [19:0] root, input bit poke_root);
    int i, j, fl, w;
    bit l1v, l2v, alt;
    logic [31:0] e1, e2;
    logic [19:0] base;
    i = int'(va[31:22]); j = int'(va[21:12]);
    alt  = (root == ROOT_B);
    base = alt ? 20'h30000 : 20'h20000;
    @(negedge clk_i);
    n_rd = 0; req_valid_i = 1'b1; req_va_i = va;
    @(negedge clk_i);
    req_valid_i = 1'b0;
    chk(req_ready_o == 1'b0, "R8 busy", 64'(req_ready_o), 64'd0);
    if (poke_root) begin
      root_we_i = 1'b1; root_frame_i = (root == ROOT_A) ? ROOT_B : ROOT_A;
      @(negedge clk_i);
      root_we_i = 1'b0;
    end
    w = 0;
    while (!rsp_valid_o && w < 200) begin @(negedge clk_i); w++; end
    l1v = (i % 7) != 3;
    l2v = ((i + j) % 5) != 2;
    e1  = {root, 12'h0} + 32'(i * 4);
    chk(addr_log[0] == e1, poke_root ? "R10 root at accept" : "R2 l1 addr", 64'(addr_log[0]), 64'(e1));
    chk(n_rd == (l1v ? 2 : 1), "R3 read count", 64'(n_rd), 64'(l1v ? 2 : 1));
    if (!l1v) begin
      chk(rsp_fault_o && rsp_fault_lvl_o == 2'd1, "R6 level1 fault",
          64'({rsp_fault_o, rsp_fault_lvl_o}), 64'({1'b1, 2'd1}));
      chk(rsp_fault_va_o == va, "R6 fault va", 64'(rsp_fault_va_o), 64'(va));
    end else begin
      e2 = {base + 20'(i), 12'h0} + 32'(j * 4);
      chk(addr_log[1] == e2, "R3 l2 addr", 64'(addr_log[1]), 64'(e2));
      if (!l2v) begin
        chk(rsp_fault_o && rsp_fault_lvl_o == 2'd2, "R7 level2 fault",
            64'({rsp_fault_o, rsp_fault_lvl_o}), 64'({1'b1, 2'd2}));
        chk(rsp_fault_va_o == va, "R7 fault va", 64'(rsp_fault_va_o), 64'(va));
      end else begin
        fl = (i * 3 + j) % 16;
        chk(!rsp_fault_o && rsp_pa_o == {l2_frame(i, j, alt), va[11:0]}, "R4 pa",
            64'({rsp_fault_o, rsp_pa_o}), 64'({1'b0, l2_frame(i, j, alt), va[11:0]}));
        chk({rsp_prot_o, rsp_mod_o, rsp_ref_o} == 4'(fl), "R5 status bits",
            64'({rsp_prot_o, rsp_mod_o, rsp_ref_o}), 64'(4'(fl)));
      end
    end
    @(negedge clk_i);
    chk(!rsp_valid_o && req_ready_o, "R8 single rsp", 64'({rsp_valid_o, req_ready_o}), 64'b01);
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    total++; bad++;
    $display("FAIL watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk_i);
    chk(req_ready_o && !rsp_valid_o && !mem_req_o, "R1 in reset",
        64'({req_ready_o, rsp_valid_o, mem_req_o}), 64'b100);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk(req_ready_o && !rsp_valid_o && !mem_req_o, "R1 after reset",
        64'({req_ready_o, rsp_valid_o, mem_req_o}), 64'b100);
    root_we_i = 1'b1; root_frame_i = ROOT_A;
    @(negedge clk_i);
    root_we_i = 1'b0;
    for (int i = 0; i < 33; i++) begin
      for (int k = 0; k < 9; k++) begin
        int ii, jj;
        logic [11:0] off;
        ii  = (i == 32) ? 1023 : i;
        jj  = (k == 8) ? 1023 : k;
        off = (k == 8) ? 12'hFFF : 12'((ii * 37 + jj * 101) % 4096);
        lat = (ii + jj) % 3;
        walk({10'(ii), 10'(jj), off}, ROOT_A, 1'b0);
      end
    end
    // R10: root write during a walk only affects later walks
    lat = 2;
    walk({10'd1, 10'd1, 12'h123}, ROOT_A, 1'b1);
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 5; j++) begin
        lat = (i * j) % 4;
        walk({10'(i), 10'(j), 12'(i * 255 + j)}, ROOT_B, 1'b0);
      end
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule